// File: doc/BRIEF.md
# Wishbone Classic Master Engine with Retry and Error Stall

This block is the far-side engine of a bus bridge. It takes transfer descriptors from the head of a first-word-fall-through address queue and turns each one into a Wishbone classic single cycle or block cycle. Write data comes from the head of a separate write-data queue. Each read beat is pushed into a read queue together with a flag that marks a failed beat. A constant address offset is added to or subtracted from every outgoing address. A watchdog limits how long a strobe may wait for a termination.

The slave can end a beat with acknowledge, retry or error. A retry costs one recovery cycle with the bus released, and then the same beat is issued again. An error on a read beat is recorded in the read queue, and the transfer goes on. An error on a write beat freezes the engine. It reports the failing address (before the offset) and the failing datum, and waits for a command from the status logic. The continue command issues the failed beat again. The abort command discards the failed beat and the beats after it in that descriptor, without any bus traffic.

Top module: `wb_classic_master`

## Requirements
- R1: After reset, `wbCycO`, `wbStbO`, `adrPop`, `wrPop` and `rdPush` are low.
- R2: A non-burst write drives `wbWeO`=1, `wbSelO`=`adrSel` and `wbDatO`= the write-queue head. On acknowledge it pops the write queue and the address queue in the same cycle.
- R3: A read beat that is acknowledged pushes `wbDatI` into the read queue with `rdErr`=0. The address queue is popped on the last beat.
- R4: When `adrBurst`=1, the descriptor holds `adrSel`+1 beats. `wbSelO` is all ones, the address rises by DATA_W/8 per beat, and `wbCycO` stays high from the first beat to the last.
- R5: `wbAdrO` equals the internal address plus OFFSET, or minus OFFSET when OFFSET_NEG=1.
- R6: A retry drops `wbCycO` and `wbStbO` for exactly one cycle and then issues the same beat again. Nothing is popped or pushed.
- R7: A write error pulses `errStrobe` for one cycle. The engine then stays off the bus and holds `errAddr` (the address without the offset) and `errData` (the failed datum) until a command arrives.
- R8: The continue command (`stuContinue`) issues the failed write beat again with the same address and data.
- R9: The abort command (`stuAbort`) pops the failed beat and every remaining beat of that descriptor from the write queue, one per cycle, with `wbCycO` low. It then pops the address queue.
- R10: A read error does not stall the engine. It pushes the beat with `rdErr`=1 and goes on to the next beat.
- R11: A strobe that gets no termination for TIMEOUT_CYC cycles is treated as an error termination: a write stalls, and a read beat is pushed with `rdErr`=1.
- R12: If abort and continue arrive in the same cycle, abort wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adrEmpty | input | 1 | Address queue is empty |
| adrAddr | input | ADDR_W | Head descriptor: byte address |
| adrSel | input | DATA_W/8 | Head descriptor: byte enables, or beat count minus one for a burst |
| adrRnw | input | 1 | Head descriptor: 1 = read |
| adrBurst | input | 1 | Head descriptor: block transfer |
| adrPop | output | 1 | Pop the address queue |
| wrData | input | DATA_W | Write-queue head |
| wrPop | output | 1 | Pop the write queue |
| rdData | output | DATA_W | Read-queue push data |
| rdErr | output | 1 | Read-queue push error flag |
| rdPush | output | 1 | Push into the read queue |
| stuAbort | input | 1 | Abort command after a write error |
| stuContinue | input | 1 | Continue command after a write error |
| errStrobe | output | 1 | One-cycle write-error report |
| errAddr | output | ADDR_W | Address of the failed write, without the offset |
| errData | output | DATA_W | Datum of the failed write |
| wbAdrO | output | ADDR_W | Wishbone address |
| wbSelO | output | DATA_W/8 | Wishbone byte selects |
| wbDatO | output | DATA_W | Wishbone write data |
| wbWeO | output | 1 | Wishbone write enable |
| wbCycO | output | 1 | Wishbone cycle |
| wbStbO | output | 1 | Wishbone strobe |
| wbDatI | input | DATA_W | Wishbone read data |
| wbAckI | input | 1 | Wishbone acknowledge |
| wbErrI | input | 1 | Wishbone error |
| wbRtyI | input | 1 | Wishbone retry |

## Verification
The hardest situation to reach is an error in the middle of a write burst followed by an abort. At that point the engine holds a partly consumed descriptor and has to discard exactly the rest of it. The bench scripts the slave's termination for each beat (acknowledge on the first beat, error on the second) and checks the reported address and datum while the engine is stalled. It then issues the abort and counts the write-queue pops. A second instance built with a negative offset runs on the same stimulus, so the subtraction path is covered without a separate run.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_READ, ST_WR_RTY, ST_RD_RTY, ST_WR_STALL
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // take the head descriptor
    logic advance;  // step to next beat address
    logic capture;  // latch failing address and datum
  } dpStrobe_t;
endpackage

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
  import wbm_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int TIMEOUT_CYC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adrEmpty,
  input  logic             adrRnw,
  input  logic             adrBurst,
  input  logic [SEL_W-1:0] adrSel,
  input  logic             wbAckI,
  input  logic             wbErrI,
  input  logic             wbRtyI,
  input  logic             stuAbort,
  input  logic             stuContinue,
  output logic             wbCycO,
  output logic             wbStbO,
  output logic             wbWeO,
  output logic             adrPop,
  output logic             wrPop,
  output logic             rdPush,
  output logic             rdErr,
  output logic             errStrobe,
  output dpStrobe_t        dp
);
  localparam int CNT_W = SEL_W + 1;
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  engState_t        state, nextState;
  logic             draining, setDrain;
  logic [CNT_W-1:0] beatsLeft;
  logic [TMO_W-1:0] tmoCnt;
  logic             busActive, term, tmoHit, lastBeat;

  assign busActive = (state == ST_WRITE && !draining) || state == ST_READ;
  assign term      = wbAckI | wbErrI | wbRtyI;
  assign tmoHit    = busActive && !term && (tmoCnt == TMO_W'(TIMEOUT_CYC - 1));
  assign lastBeat  = (beatsLeft == CNT_W'(1));

  assign wbCycO = busActive;
  assign wbStbO = busActive;
  assign wbWeO  = (state == ST_WRITE) && !draining;

  always_comb begin
    nextState = state;
    dp        = '0;
    adrPop    = 1'b0;
    wrPop     = 1'b0;
    rdPush    = 1'b0;
    rdErr     = 1'b0;
    errStrobe = 1'b0;
    setDrain  = 1'b0;
    unique case (state)
      ST_IDLE: if (!adrEmpty) begin
        dp.load   = 1'b1;
        nextState = adrRnw ? ST_READ : ST_WRITE;
      end
      ST_WRITE: begin
        if (draining || wbAckI) begin
          wrPop      = 1'b1;
          dp.advance = 1'b1;
          if (lastBeat) begin
            adrPop    = 1'b1;
            nextState = ST_IDLE;
          end
        end else if (wbRtyI) begin
          nextState = ST_WR_RTY;
        end else if (wbErrI || tmoHit) begin
          errStrobe  = 1'b1;
          dp.capture = 1'b1;
          nextState  = ST_WR_STALL;
        end
      end
      ST_READ: begin
        if (wbAckI || (!wbRtyI && (wbErrI || tmoHit))) begin
          rdPush     = 1'b1;
          rdErr      = !wbAckI;
          dp.advance = 1'b1;
          if (lastBeat) begin
            adrPop    = 1'b1;
            nextState = ST_IDLE;
          end
        end else if (wbRtyI) begin
          nextState = ST_RD_RTY;
        end
      end
      ST_WR_RTY: nextState = ST_WRITE;
      ST_RD_RTY: nextState = ST_READ;
      ST_WR_STALL: begin
        if (stuAbort) begin
          setDrain  = 1'b1;
          nextState = ST_WRITE;
        end else if (stuContinue) begin
          nextState = ST_WRITE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      draining  <= 1'b0;
      beatsLeft <= '0;
      tmoCnt    <= '0;
    end else begin
      state <= nextState;
      if (setDrain)
        draining <= 1'b1;
      else if (draining && lastBeat && state == ST_WRITE)
        draining <= 1'b0;
      if (dp.load)
        beatsLeft <= adrBurst ? ({1'b0, adrSel} + CNT_W'(1)) : CNT_W'(1);
      else if (dp.advance)
        beatsLeft <= beatsLeft - CNT_W'(1);
      if (busActive && !term && !tmoHit)
        tmoCnt <= tmoCnt + TMO_W'(1);
      else
        tmoCnt <= '0;
    end
  end
endmodule

// File: rtl/wbm_datapath.sv
module wbm_datapath
  import wbm_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              DATA_W     = 32,
  parameter logic [ADDR_W-1:0] OFFSET   = '0,
  parameter bit              OFFSET_NEG = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobe_t             dp,
  input  logic [ADDR_W-1:0]     adrAddr,
  input  logic [DATA_W/8-1:0]   adrSel,
  input  logic                  adrBurst,
  input  logic [DATA_W-1:0]     wrData,
  output logic [ADDR_W-1:0]     wbAdrO,
  output logic [DATA_W/8-1:0]   wbSelO,
  output logic [DATA_W-1:0]     wbDatO,
  output logic [ADDR_W-1:0]     errAddr,
  output logic [DATA_W-1:0]     errData
);
  localparam int SEL_W = DATA_W / 8;

  logic [ADDR_W-1:0] curAddr;
  logic [SEL_W-1:0]  curSel;
  logic              curBurst;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr  <= '0;
      curSel   <= '0;
      curBurst <= 1'b0;
      errAddr  <= '0;
      errData  <= '0;
    end else begin
      if (dp.load) begin
        curAddr  <= adrAddr;
        curSel   <= adrSel;
        curBurst <= adrBurst;
      end else if (dp.advance) begin
        curAddr <= curAddr + ADDR_W'(SEL_W);
      end
      if (dp.capture) begin
        errAddr <= curAddr;
        errData <= wrData;
      end
    end
  end

  generate
    if (OFFSET_NEG) begin : g_sub
      assign wbAdrO = curAddr - OFFSET;
    end else begin : g_add
      assign wbAdrO = curAddr + OFFSET;
    end
  endgenerate

  assign wbSelO = curBurst ? {SEL_W{1'b1}} : curSel;
  assign wbDatO = wrData;
endmodule

// File: rtl/wb_classic_master.sv
module wb_classic_master
  import wbm_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] OFFSET      = 32'h0000_1000,
  parameter bit                OFFSET_NEG  = 1'b0,
  parameter int                TIMEOUT_CYC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adrEmpty,
  input  logic [ADDR_W-1:0]   adrAddr,
  input  logic [DATA_W/8-1:0] adrSel,
  input  logic                adrRnw,
  input  logic                adrBurst,
  output logic                adrPop,
  input  logic [DATA_W-1:0]   wrData,
  output logic                wrPop,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdErr,
  output logic                rdPush,
  input  logic                stuAbort,
  input  logic                stuContinue,
  output logic                errStrobe,
  output logic [ADDR_W-1:0]   errAddr,
  output logic [DATA_W-1:0]   errData,
  output logic [ADDR_W-1:0]   wbAdrO,
  output logic [DATA_W/8-1:0] wbSelO,
  output logic [DATA_W-1:0]   wbDatO,
  output logic                wbWeO,
  output logic                wbCycO,
  output logic                wbStbO,
  input  logic [DATA_W-1:0]   wbDatI,
  input  logic                wbAckI,
  input  logic                wbErrI,
  input  logic                wbRtyI
);
  localparam int SEL_W = DATA_W / 8;

  dpStrobe_t dp;

  wbm_ctrl #(.SEL_W(SEL_W), .TIMEOUT_CYC(TIMEOUT_CYC)) ctrl_i (
    .clk(clk), .rst(rst), .adrEmpty(adrEmpty), .adrRnw(adrRnw),
    .adrBurst(adrBurst), .adrSel(adrSel), .wbAckI(wbAckI), .wbErrI(wbErrI),
    .wbRtyI(wbRtyI), .stuAbort(stuAbort), .stuContinue(stuContinue),
    .wbCycO(wbCycO), .wbStbO(wbStbO), .wbWeO(wbWeO), .adrPop(adrPop),
    .wrPop(wrPop), .rdPush(rdPush), .rdErr(rdErr), .errStrobe(errStrobe),
    .dp(dp)
  );

  wbm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET),
                 .OFFSET_NEG(OFFSET_NEG)) dpath_i (
    .clk(clk), .rst(rst), .dp(dp), .adrAddr(adrAddr), .adrSel(adrSel),
    .adrBurst(adrBurst), .wrData(wrData), .wbAdrO(wbAdrO), .wbSelO(wbSelO),
    .wbDatO(wbDatO), .errAddr(errAddr), .errData(errData)
  );

  assign rdData = wbDatI;
endmodule

// File: rtl/wbm_checker.sv
module wbm_checker #(
  parameter int ADDR_W      = 32,
  parameter int TIMEOUT_CYC = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              adrEmpty,
  input logic              adrPop,
  input logic              rdPush,
  input logic              errStrobe,
  input logic              wbCycO,
  input logic              wbStbO,
  input logic              wbWeO,
  input logic              wbAckI,
  input logic              wbErrI,
  input logic              wbRtyI,
  input logic [ADDR_W-1:0] wbAdrO
);
  logic        anyTerm;
  int unsigned waitCnt;

  assign anyTerm = wbAckI | wbErrI | wbRtyI;

  always_ff @(posedge clk) begin
    if (rst || !wbStbO || anyTerm || rdPush || errStrobe) waitCnt <= 0;
    else waitCnt <= waitCnt + 1;
  end

  // R1
  stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    wbStbO |-> wbCycO);

  // R6
  rty_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (wbStbO && wbRtyI && !wbAckI) |=> !wbCycO ##1 wbCycO);

  // R7
  wr_err_report_chk: assert property (@(posedge clk) disable iff (rst)
    (wbStbO && wbWeO && wbErrI && !wbAckI && !wbRtyI) |-> errStrobe);

  // R7
  stall_off_bus_chk: assert property (@(posedge clk) disable iff (rst)
    errStrobe |=> !wbCycO);

  // R2
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    adrPop |-> !adrEmpty);

  // R3
  push_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    rdPush |-> (wbCycO && !wbWeO));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wbStbO && !anyTerm && !rdPush && !errStrobe) |=> (!wbStbO || $stable(wbAdrO)));

  // R11
  watchdog_limit_chk: assert property (@(posedge clk) disable iff (rst)
    waitCnt < TIMEOUT_CYC);
endmodule

bind wb_classic_master wbm_checker #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
  .clk(clk), .rst(rst), .adrEmpty(adrEmpty), .adrPop(adrPop), .rdPush(rdPush),
  .errStrobe(errStrobe), .wbCycO(wbCycO), .wbStbO(wbStbO), .wbWeO(wbWeO),
  .wbAckI(wbAckI), .wbErrI(wbErrI), .wbRtyI(wbRtyI), .wbAdrO(wbAdrO)
);

// File: tb/wb_classic_master_tb.sv
module wb_classic_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OFF = 32'h0000_1000;
  localparam int TMO = 8;
  localparam logic [1:0] R_ACK = 2'd0, R_ERR = 2'd1, R_RTY = 2'd2, R_NONE = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  // queue models
  logic [31:0] adrQA [0:63];
  logic [3:0]  adrQS [0:63];
  logic        adrQR [0:63];
  logic        adrQB [0:63];
  logic [31:0] wrQ   [0:63];
  logic [1:0]  respQ [0:63];
  int adrHead = 0, adrTail = 0, wrHead = 0, wrTail = 0, respHead = 0, respTail = 0;

  logic stuAbort = 1'b0, stuContinue = 1'b0;
  logic adrEmpty, adrPop, wrPop, rdErr, rdPush, errStrobe, wbWeO, wbCycO, wbStbO;
  logic wbAckI, wbErrI, wbRtyI;
  logic [31:0] adrAddr, wrData, rdData, errAddr, errData, wbAdrO, wbDatO, wbDatI;
  logic [3:0]  adrSel, wbSelO;
  logic        adrRnw, adrBurst;
  logic [1:0]  code;

  assign adrEmpty = (adrHead == adrTail);
  assign adrAddr  = adrQA[adrHead];
  assign adrSel   = adrQS[adrHead];
  assign adrRnw   = adrQR[adrHead];
  assign adrBurst = adrQB[adrHead];
  assign wrData   = wrQ[wrHead];
  assign code     = (respHead < respTail) ? respQ[respHead] : R_NONE;
  assign wbAckI   = wbStbO && code == R_ACK;
  assign wbErrI   = wbStbO && code == R_ERR;
  assign wbRtyI   = wbStbO && code == R_RTY;
  assign wbDatI   = 32'hC0DE_0000 | {16'h0, wbAdrO[15:0]};

  wb_classic_master #(.OFFSET(OFF), .OFFSET_NEG(1'b0), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .adrEmpty(adrEmpty), .adrAddr(adrAddr), .adrSel(adrSel),
    .adrRnw(adrRnw), .adrBurst(adrBurst), .adrPop(adrPop), .wrData(wrData),
    .wrPop(wrPop), .rdData(rdData), .rdErr(rdErr), .rdPush(rdPush),
    .stuAbort(stuAbort), .stuContinue(stuContinue), .errStrobe(errStrobe),
    .errAddr(errAddr), .errData(errData), .wbAdrO(wbAdrO), .wbSelO(wbSelO),
    .wbDatO(wbDatO), .wbWeO(wbWeO), .wbCycO(wbCycO), .wbStbO(wbStbO),
    .wbDatI(wbDatI), .wbAckI(wbAckI), .wbErrI(wbErrI), .wbRtyI(wbRtyI)
  );

  // second instance with subtracted offset, same stimulus
  logic nAdrPop, nWrPop, nRdErr, nRdPush, nErrStrobe, nWe, nCyc, nStb;
  logic [31:0] nRdData, nErrAddr, nErrData, nAdr, nDat;
  logic [3:0]  nSel;
  wb_classic_master #(.OFFSET(OFF), .OFFSET_NEG(1'b1), .TIMEOUT_CYC(TMO)) dutNeg_i (
    .clk(clk), .rst(rst), .adrEmpty(adrEmpty), .adrAddr(adrAddr), .adrSel(adrSel),
    .adrRnw(adrRnw), .adrBurst(adrBurst), .adrPop(nAdrPop), .wrData(wrData),
    .wrPop(nWrPop), .rdData(nRdData), .rdErr(nRdErr), .rdPush(nRdPush),
    .stuAbort(stuAbort), .stuContinue(stuContinue), .errStrobe(nErrStrobe),
    .errAddr(nErrAddr), .errData(nErrData), .wbAdrO(nAdr), .wbSelO(nSel),
    .wbDatO(nDat), .wbWeO(nWe), .wbCycO(nCyc), .wbStbO(nStb),
    .wbDatI(wbDatI), .wbAckI(wbAckI), .wbErrI(wbErrI), .wbRtyI(wbRtyI)
  );

  always @(posedge clk) begin
    if (adrPop) adrHead <= adrHead + 1;
    if (wrPop)  wrHead  <= wrHead + 1;
    if (wbStbO && (wbAckI || wbErrI || wbRtyI || errStrobe || rdPush))
      respHead <= respHead + 1;
  end

  // logs sampled mid-cycle
  logic [31:0] bAddr [0:63];
  logic [31:0] bNeg  [0:63];
  logic [31:0] bDat  [0:63];
  logic [3:0]  bSel  [0:63];
  logic        bWe   [0:63];
  logic [31:0] rData [0:63];
  logic        rErr  [0:63];
  int beatN = 0, rdN = 0, stbCnt = 0, cycCnt = 0, errN = 0;

  always @(negedge clk) begin
    if (wbStbO) stbCnt++;
    if (wbCycO) cycCnt++;
    if (errStrobe) errN++;
    if (wbStbO && wbAckI) begin
      bAddr[beatN] = wbAdrO; bNeg[beatN] = nAdr; bDat[beatN] = wbDatO;
      bSel[beatN] = wbSelO;  bWe[beatN] = wbWeO;
      beatN++;
    end
    if (rdPush) begin
      rData[rdN] = rdData; rErr[rdN] = rdErr;
      rdN++;
    end
  end

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushAdr(input logic [31:0] a, input logic [3:0] s, input logic r, input logic b);
    adrQA[adrTail] = a; adrQS[adrTail] = s; adrQR[adrTail] = r; adrQB[adrTail] = b;
    adrTail++;
  endtask
  task automatic pushWr(input logic [31:0] d);
    wrQ[wrTail] = d; wrTail++;
  endtask
  task automatic pushResp(input logic [1:0] c);
    respQ[respTail] = c; respTail++;
  endtask
  task automatic waitIdle();
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (adrHead == adrTail && !wbCycO) break;
    end
    repeat (2) @(posedge clk);
    #1;
  endtask
  task automatic pulse(input bit ab, input bit co);
    @(posedge clk); #1;
    stuAbort = ab; stuContinue = co;
    @(posedge clk); #1;
    stuAbort = 1'b0; stuContinue = 1'b0;
  endtask

  task automatic t_reset();
    checkEq("R1 cyc", {31'd0, wbCycO}, 32'd0);
    checkEq("R1 stb", {31'd0, wbStbO}, 32'd0);
    checkEq("R1 pops", {29'd0, adrPop, wrPop, rdPush}, 32'd0);
  endtask

  task automatic t_single_write();
    int b0, w0;
    b0 = beatN; w0 = wrHead;
    pushResp(R_ACK); pushWr(32'hDEAD_BEEF); pushAdr(32'h100, 4'b0011, 1'b0, 1'b0);
    waitIdle();
    checkEq("R2 beats", beatN - b0, 1);
    checkEq("R5 add offset", bAddr[b0], 32'h1100);
    checkEq("R5 sub offset", bNeg[b0], 32'hFFFF_F100);
    checkEq("R2 sel", {28'd0, bSel[b0]}, 32'h3);
    checkEq("R2 we", {31'd0, bWe[b0]}, 32'd1);
    checkEq("R2 data", bDat[b0], 32'hDEAD_BEEF);
    checkEq("R2 wr pop", wrHead - w0, 1);
  endtask

  task automatic t_single_read();
    int r0;
    r0 = rdN;
    pushResp(R_ACK); pushAdr(32'h200, 4'b1111, 1'b1, 1'b0);
    waitIdle();
    checkEq("R3 pushes", rdN - r0, 1);
    checkEq("R3 data", rData[r0], 32'hC0DE_1200);
    checkEq("R3 err", {31'd0, rErr[r0]}, 32'd0);
  endtask

  task automatic t_retry();
    int b0, s0;
    b0 = beatN; s0 = stbCnt;
    pushResp(R_RTY); pushResp(R_ACK); pushWr(32'h0000_0055);
    pushAdr(32'h300, 4'b0001, 1'b0, 1'b0);
    waitIdle();
    checkEq("R6 strobe cycles", stbCnt - s0, 2);
    checkEq("R6 beats", beatN - b0, 1);
    checkEq("R6 same addr", bAddr[b0], 32'h1300);
  endtask

  task automatic t_burst_read();
    int r0, b0, c0;
    r0 = rdN; b0 = beatN; c0 = cycCnt;
    pushResp(R_ACK); pushResp(R_ERR); pushResp(R_ACK); pushResp(R_ACK);
    pushAdr(32'h400, 4'd3, 1'b1, 1'b1);
    waitIdle();
    checkEq("R4 beats", rdN - r0, 4);
    checkEq("R4 cyc held", cycCnt - c0, 4);
    checkEq("R4 sel all ones", {28'd0, bSel[b0]}, 32'hF);
    checkEq("R4 third addr", bAddr[b0 + 1], 32'h1408);
    checkEq("R4 last addr", bAddr[b0 + 2], 32'h140C);
    checkEq("R3 burst data", rData[r0 + 2], 32'hC0DE_1408);
    checkEq("R10 err flags", {28'd0, rErr[r0], rErr[r0+1], rErr[r0+2], rErr[r0+3]}, 32'b0100);
  endtask

  task automatic t_stall_continue();
    int b0, s0, e0, a0;
    b0 = beatN; s0 = stbCnt; e0 = errN; a0 = adrHead;
    pushResp(R_ERR); pushResp(R_ACK); pushWr(32'h1111_2222);
    pushAdr(32'h500, 4'b1100, 1'b0, 1'b0);
    repeat (6) @(posedge clk);
    #1;
    checkEq("R7 err strobe", errN - e0, 1);
    checkEq("R7 stalled", stbCnt - s0, 1);
    checkEq("R7 err addr", errAddr, 32'h500);
    checkEq("R7 err data", errData, 32'h1111_2222);
    checkEq("R7 no pop", adrHead - a0, 0);
    pulse(1'b0, 1'b1);
    waitIdle();
    checkEq("R8 beats", beatN - b0, 1);
    checkEq("R8 addr", bAddr[b0], 32'h1500);
    checkEq("R8 data", bDat[b0], 32'h1111_2222);
  endtask

  task automatic t_abort_burst();
    int b0, s0, w0;
    b0 = beatN; s0 = stbCnt; w0 = wrHead;
    pushResp(R_ACK); pushResp(R_ERR);
    pushWr(32'hA0); pushWr(32'hA1); pushWr(32'hA2);
    pushAdr(32'h600, 4'd2, 1'b0, 1'b1);
    repeat (8) @(posedge clk);
    #1;
    checkEq("R7 burst err addr", errAddr, 32'h604);
    checkEq("R7 burst err data", errData, 32'hA1);
    pulse(1'b1, 1'b0);
    waitIdle();
    checkEq("R9 beats", beatN - b0, 1);
    checkEq("R9 strobes", stbCnt - s0, 2);
    checkEq("R9 wr pops", wrHead - w0, 3);
    checkEq("R9 adr popped", {31'd0, adrEmpty}, 32'd1);
  endtask

  task automatic t_abort_wins();
    int b0, s0, w0;
    b0 = beatN; s0 = stbCnt; w0 = wrHead;
    pushResp(R_ERR); pushWr(32'h77); pushAdr(32'h700, 4'b1111, 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    pulse(1'b1, 1'b1);
    waitIdle();
    checkEq("R12 no reissue", beatN - b0, 0);
    checkEq("R12 strobes", stbCnt - s0, 1);
    checkEq("R12 wr pop", wrHead - w0, 1);
  endtask

  task automatic t_timeout();
    int r0, s0;
    r0 = rdN; s0 = stbCnt;
    pushResp(R_NONE); pushAdr(32'h800, 4'b1111, 1'b1, 1'b0);
    waitIdle();
    checkEq("R11 strobes", stbCnt - s0, TMO);
    checkEq("R11 push", rdN - r0, 1);
    checkEq("R11 err", {31'd0, rErr[r0]}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_single_write();
    t_single_read();
    t_retry();
    t_burst_read();
    t_stall_continue();
    t_abort_burst();
    t_abort_wins();
    t_timeout();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule